// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block decides, one decoded command at a time, whether a serial-flash command may run. A front end that has already shifted in the opcode, the target address and the status data byte presents them for one cycle on `cmd_valid`. It also gives the number of serial clock pulses counted while chip select was low. One cycle later the controller answers with exactly one pulse, either `cmd_exec` or `cmd_reject`, and updates the protection state it owns. That state is the write-enable latch, the three block-protect bits and the status-protect bit, which also serves as the one-time-programmable lock.

A command is refused for several reasons. The chip may be in deep power-down. The power-up timer may not have expired since reset. A modifying command may have a clock count that is not a whole number of bytes, or the write-enable latch may be clear. The one-time lock may be set, or the hardware protect condition may hold. The address may fall in a protected area. Refusals caused by a protected area still consume the write-enable latch; every other refusal leaves all state untouched. The shifter, the array, erase and program timing and the analog power-on timer sit outside this block. The timer is seen only as a one-cycle pulse.

Top module: `flash_wp_ctrl`

## Requirements
- R1: WRSR (3), PP (4), SE (5), BE (6) and CE (7) are rejected when `cmd_clks` is not a multiple of 8, and the latch and status bits stay unchanged.
- R2: A modifying command (opcodes 3..7) arriving while `wel` is 0 is rejected.
- R3: WREN (1) sets `wel`. Reset clears it, and so does any executed WRDI (2), WRSR, PP, SE, BE or CE.
- R4: Outside one-time mode, when `srp_lock` is 1 and `wp_n` is 0, WRSR is rejected and `bp` and `srp_lock` keep their values. Otherwise an executed WRSR loads `bp` from `sts_wdata[2:0]` and `srp_lock` from `sts_wdata[3]`.
- R5: While `dpd_active` is 1, only release (8) executes. Every other opcode is rejected with no state change.
- R6: With `otp_mode` at 1, an executed WRSR ignores `sts_wdata`, keeps `bp` and sets `srp_lock` to 1. A lock set this way is never cleared until reset, not even by a later WRSR outside one-time mode. In one-time mode with `srp_lock` at 1, PP, SE, BE and CE are rejected.
- R7: PP and SE are rejected when the address lies in the protected area. For bp=000 the area is empty. For 101 it is 0x0000..0xDFFF, for 110 it is 0x0000..0xEFFF, and for 001, 010, 011, 100 and 111 it is the whole array. Such a rejection still clears `wel`.
- R8: BE and CE are rejected whenever `bp` is nonzero, and the rejection clears `wel`. With `bp` at 000 they execute.
- R9: After reset, every modifying command is rejected until `pwr_timer_done` has pulsed.
- R10: Each `cmd_valid` cycle produces exactly one one-cycle pulse on `cmd_exec` or `cmd_reject` in the following cycle. Neither pulses without a command. Opcodes 0 (no-op) and 9 (read) execute outside deep power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is presented |
| cmd_op | input | 4 | Decoded opcode (encoding in R1..R10) |
| cmd_addr | input | ADDR_W (16) | Target byte address |
| cmd_clks | input | CNT_W (8) | Serial clock pulses seen while chip select was low |
| sts_wdata | input | 4 | Status data for WRSR: [3] protect/lock, [2:0] block-protect |
| wp_n | input | 1 | Write-protect pin, active low |
| pwr_timer_done | input | 1 | Pulse: the power-up timer has expired |
| otp_mode | input | 1 | One-time-programmable mode is active |
| dpd_active | input | 1 | Deep power-down state |
| cmd_exec | output | 1 | Pulse: command accepted |
| cmd_reject | output | 1 | Pulse: command refused |
| wel | output | 1 | Write-enable latch |
| bp | output | 3 | Block-protect bits |
| srp_lock | output | 1 | Status-protect bit / one-time lock |

## Verification
The acceptance decision is tried with commands that each break exactly one rule while meeting all the others. A count of 33 against 40 isolates the byte-multiple rule. A clear latch with a good count isolates the latch rule. Addresses on either side of 0xE000 and 0xF000 probe the edges of the area encodings. The pin and mode inputs are toggled around the same WRSR so that hardware protection, the sticky lock and the data-ignoring write in one-time mode can be told apart. Each refusal is followed by reading `wel`, which separates area refusals (latch consumed) from gate refusals (latch kept).

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_WREN = 4'd1,
    OP_WRDI = 4'd2,
    OP_WRSR = 4'd3,
    OP_PP   = 4'd4,
    OP_SE   = 4'd5,
    OP_BE   = 4'd6,
    OP_CE   = 4'd7,
    OP_RDP  = 4'd8,
    OP_READ = 4'd9
  } wp_op_e;

  typedef enum logic [2:0] {
    RSN_NONE,
    RSN_DPD,
    RSN_PWR,
    RSN_CNT,
    RSN_WEL,
    RSN_OTP,
    RSN_HPM,
    RSN_AREA
  } wp_reason_e;

  // Commands that alter array or status contents.
  function automatic logic is_modify(logic [3:0] op);
    return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) ||
           (op == OP_BE) || (op == OP_CE);
  endfunction

  // Number of bytes from address zero that a block-protect code covers.
  function automatic int unsigned prot_bytes(logic [2:0] code, int unsigned size);
    case (code)
      3'b000:  return 0;
      3'b101:  return size - size / 8;
      3'b110:  return size - size / 16;
      default: return size;
    endcase
  endfunction

endpackage

// File: rtl/wp_gate.sv
module wp_gate
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  clks,
  input  logic              dpd,
  input  logic              powered,
  input  logic              wel,
  input  logic [2:0]        bp,
  input  logic              srp,
  input  logic              otp_mode,
  input  logic              wp_n,
  output logic              accept,
  output logic              area_refuse
);

  localparam int unsigned ARRAY_BYTES = 1 << ADDR_W;

  wp_reason_e reason;
  logic       count_ok;
  logic       addr_hit;
  logic       erase_all;
  logic       mod;

  assign count_ok  = (clks & CNT_W'(7)) == '0;
  assign addr_hit  = 32'(addr) < prot_bytes(bp, ARRAY_BYTES);
  assign erase_all = (op == OP_BE) || (op == OP_CE);
  assign mod       = is_modify(op);

  // Priority chain: earlier refusals hide later ones.
  always_comb begin
    reason = RSN_NONE;
    if (dpd) begin
      if (op != OP_RDP) reason = RSN_DPD;
    end else if (mod) begin
      if (!powered)                                   reason = RSN_PWR;
      else if (!count_ok)                             reason = RSN_CNT;
      else if (!wel)                                  reason = RSN_WEL;
      else if (otp_mode && srp && op != OP_WRSR)      reason = RSN_OTP;
      else if (!otp_mode && srp && !wp_n && op == OP_WRSR) reason = RSN_HPM;
      else if ((op == OP_PP || op == OP_SE) && addr_hit)  reason = RSN_AREA;
      else if (erase_all && bp != 3'b000)             reason = RSN_AREA;
    end
  end

  assign accept      = (reason == RSN_NONE);
  assign area_refuse = (reason == RSN_AREA);

endmodule

// File: rtl/wp_status_regs.sv
module wp_status_regs
  import flash_wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [3:0] op,
  input  logic [3:0] wdata,
  input  logic       otp_mode,
  input  logic       pwr_done,
  input  logic       accept,
  input  logic       area_refuse,
  output logic       exec_q,
  output logic       rej_q,
  output logic       wel,
  output logic [2:0] bp,
  output logic       srp,
  output logic       fused,
  output logic       powered
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q  <= 1'b0;
      rej_q   <= 1'b0;
      wel     <= 1'b0;
      bp      <= 3'b000;
      srp     <= 1'b0;
      fused   <= 1'b0;
      powered <= 1'b0;
    end else begin
      if (pwr_done) powered <= 1'b1;
      exec_q <= cmd_valid && accept;
      rej_q  <= cmd_valid && !accept;
      if (cmd_valid) begin
        if (accept) begin
          case (op)
            OP_WREN: wel <= 1'b1;
            OP_WRDI: wel <= 1'b0;
            OP_WRSR: begin
              wel <= 1'b0;
              if (otp_mode) begin
                srp   <= 1'b1;
                fused <= 1'b1;
              end else begin
                bp  <= wdata[2:0];
                srp <= wdata[3] | fused;
              end
            end
            OP_PP, OP_SE, OP_BE, OP_CE: wel <= 1'b0;
            default: ;
          endcase
        end else if (area_refuse) begin
          wel <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_clks,
  input  logic [3:0]        sts_wdata,
  input  logic              wp_n,
  input  logic              pwr_timer_done,
  input  logic              otp_mode,
  input  logic              dpd_active,
  output logic              cmd_exec,
  output logic              cmd_reject,
  output logic              wel,
  output logic [2:0]        bp,
  output logic              srp_lock
);

  // Named internal events, visible to the bound checker.
  logic gate_accept;
  logic gate_area;
  logic otp_fused;
  logic pwr_ok;

  wp_gate #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_gate (
    .op          (cmd_op),
    .addr        (cmd_addr),
    .clks        (cmd_clks),
    .dpd         (dpd_active),
    .powered     (pwr_ok),
    .wel         (wel),
    .bp          (bp),
    .srp         (srp_lock),
    .otp_mode    (otp_mode),
    .wp_n        (wp_n),
    .accept      (gate_accept),
    .area_refuse (gate_area)
  );

  wp_status_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .op          (cmd_op),
    .wdata       (sts_wdata),
    .otp_mode    (otp_mode),
    .pwr_done    (pwr_timer_done),
    .accept      (gate_accept),
    .area_refuse (gate_area),
    .exec_q      (cmd_exec),
    .rej_q       (cmd_reject),
    .wel         (wel),
    .bp          (bp),
    .srp         (srp_lock),
    .fused       (otp_fused),
    .powered     (pwr_ok)
  );

endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk
  import flash_wp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic [CNT_W-1:0] cmd_clks,
  input logic             wp_n,
  input logic             otp_mode,
  input logic             dpd_active,
  input logic             cmd_exec,
  input logic             cmd_reject,
  input logic             wel,
  input logic [2:0]       bp,
  input logic             srp_lock,
  input logic             otp_fused,
  input logic             gate_accept
);

  // R10
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_exec, cmd_reject}));

  // R10
  answer_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (cmd_exec || cmd_reject));

  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !(cmd_exec || cmd_reject));

  // R10
  accept_maps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && gate_accept) |=> cmd_exec);

  // R1
  byte_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_modify(cmd_op) && (cmd_clks & CNT_W'(7)) != '0)
      |=> (cmd_reject && $stable(wel) && $stable(bp) && $stable(srp_lock)));

  // R2
  latch_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_modify(cmd_op) && !wel) |=> cmd_reject);

  // R3
  latch_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exec && $past(cmd_valid && is_modify(cmd_op))) |-> !wel);

  // R4
  hw_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRSR && !otp_mode && srp_lock && !wp_n)
      |=> (cmd_reject && $stable(bp) && $stable(srp_lock)));

  // R5
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dpd_active && cmd_op != OP_RDP)
      |=> (cmd_reject && $stable(wel) && $stable(bp) && $stable(srp_lock)));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otp_fused |-> srp_lock);

endmodule

bind flash_wp_ctrl flash_wp_chk #(.CNT_W(CNT_W)) u_flash_wp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_clks    (cmd_clks),
  .wp_n        (wp_n),
  .otp_mode    (otp_mode),
  .dpd_active  (dpd_active),
  .cmd_exec    (cmd_exec),
  .cmd_reject  (cmd_reject),
  .wel         (wel),
  .bp          (bp),
  .srp_lock    (srp_lock),
  .otp_fused   (otp_fused),
  .gate_accept (gate_accept)
);

// File: tb/test_flash_wp_ctrl.sv
module test_flash_wp_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [15:0] cmd_addr = 16'd0;
  logic [7:0]  cmd_clks = 8'd0;
  logic [3:0]  sts_wdata = 4'd0;
  logic        wp_n = 1'b1;
  logic        pwr_timer_done = 1'b0;
  logic        otp_mode = 1'b0;
  logic        dpd_active = 1'b0;
  logic        cmd_exec, cmd_reject, wel, srp_lock;
  logic [2:0]  bp;

  always #2.5 clk = ~clk;

  flash_wp_ctrl i_flash_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_clks(cmd_clks), .sts_wdata(sts_wdata),
    .wp_n(wp_n), .pwr_timer_done(pwr_timer_done), .otp_mode(otp_mode),
    .dpd_active(dpd_active), .cmd_exec(cmd_exec), .cmd_reject(cmd_reject),
    .wel(wel), .bp(bp), .srp_lock(srp_lock)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string cur_tag = "R10";

  // Reference model state.
  int m_wel = 0, m_bp = 0, m_srp = 0, m_fused = 0, m_pwr = 0;
  int m_exec = 0, m_rej = 0;

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
    end
  endtask

  // One clock: sample every output against the model after the edge.
  task automatic tick();
    @(negedge clk);
    chk("exec",   int'(cmd_exec),   m_exec);
    chk("reject", int'(cmd_reject), m_rej);
    chk("wel",    int'(wel),        m_wel);
    chk("bp",     int'(bp),         m_bp);
    chk("srp",    int'(srp_lock),   m_srp);
  endtask

  function automatic int area_top(int code);
    if (code == 0) return 0;
    if (code == 5) return 57344;
    if (code == 6) return 61440;
    return 65536;
  endfunction

  // Returns 0 accept, 1 plain refusal, 2 refusal that consumes the latch.
  function automatic int judge(int op, int addr, int clks);
    bit writes = (op >= 3) && (op <= 7);
    if (dpd_active) return (op == 8) ? 0 : 1;
    if (!writes) return 0;
    if (m_pwr == 0) return 1;
    if (clks % 8 != 0) return 1;
    if (m_wel == 0) return 1;
    if (otp_mode && m_srp == 1 && op != 3) return 1;
    if (!otp_mode && op == 3 && m_srp == 1 && !wp_n) return 1;
    if ((op == 4 || op == 5) && addr < area_top(m_bp)) return 2;
    if ((op == 6 || op == 7) && m_bp != 0) return 2;
    return 0;
  endfunction

  task automatic cmd(int op, int addr, int clks, int data, string tag);
    int verdict;
    verdict = judge(op, addr, clks);
    cmd_op = 4'(op); cmd_addr = 16'(addr); cmd_clks = 8'(clks);
    sts_wdata = 4'(data); cmd_valid = 1'b1;
    m_exec = (verdict == 0) ? 1 : 0;
    m_rej  = (verdict == 0) ? 0 : 1;
    if (verdict == 2) m_wel = 0;
    if (verdict == 0) begin
      if (op == 1) m_wel = 1;
      else if (op == 2) m_wel = 0;
      else if (op >= 3 && op <= 7) m_wel = 0;
      if (op == 3) begin
        if (otp_mode) begin m_srp = 1; m_fused = 1; end
        else begin m_bp = data % 8; m_srp = ((data / 8) % 2) | m_fused; end
      end
    end
    cur_tag = tag;
    tick();
    cmd_valid = 1'b0;
    m_exec = 0; m_rej = 0;
    tick();
  endtask

  task automatic do_reset(string tag);
    cur_tag = tag;
    rst_n = 1'b0;
    m_wel = 0; m_bp = 0; m_srp = 0; m_fused = 0; m_pwr = 0;
    m_exec = 0; m_rej = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic power_up();
    pwr_timer_done = 1'b1;
    m_pwr = 1;
    tick();
    pwr_timer_done = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R3 / R10 reset state
    do_reset("R3");
    // R9: latch set, but timer not yet expired
    cmd(1, 0, 8, 0, "R3");
    cmd(4, 16'h1000, 40, 0, "R9");
    power_up();
    // R1: 33 clocks is not a byte multiple, latch kept
    cmd(4, 16'h1000, 33, 0, "R1");
    cmd(3, 0, 17, 5, "R1");
    cmd(4, 16'h1000, 40, 0, "R3");
    // R2: latch now clear
    cmd(4, 16'h1000, 40, 0, "R2");
    cmd(7, 0, 8, 0, "R2");
    // R4 normal write of bp=101
    cmd(1, 0, 8, 0, "R3");
    cmd(3, 0, 16, 4'b0101, "R4");
    // R7 edges of 101
    cmd(1, 0, 8, 0, "R3");
    cmd(4, 16'hDFFF, 40, 0, "R7");
    cmd(1, 0, 8, 0, "R3");
    cmd(4, 16'hE000, 40, 0, "R7");
    // R8 with nonzero bp
    cmd(1, 0, 8, 0, "R3");
    cmd(6, 0, 32, 0, "R8");
    cmd(1, 0, 8, 0, "R3");
    cmd(7, 0, 8, 0, "R8");
    // bp=110 with protect bit set, R7 edges
    cmd(1, 0, 8, 0, "R3");
    cmd(3, 0, 16, 4'b1110, "R4");
    cmd(1, 0, 8, 0, "R3");
    cmd(5, 16'hEFFF, 32, 0, "R7");
    cmd(1, 0, 8, 0, "R3");
    cmd(5, 16'hF000, 32, 0, "R7");
    // R4 hardware protection
    wp_n = 1'b0;
    cmd(1, 0, 8, 0, "R3");
    cmd(3, 0, 16, 4'b0000, "R4");
    wp_n = 1'b1;
    cmd(3, 0, 16, 4'b0000, "R4");
    // R3 write-disable
    cmd(1, 0, 8, 0, "R3");
    cmd(2, 0, 8, 0, "R3");
    // R7 code 001 protects everything
    cmd(1, 0, 8, 0, "R3");
    cmd(3, 0, 16, 4'b0001, "R7");
    cmd(1, 0, 8, 0, "R3");
    cmd(4, 16'hFFFF, 40, 0, "R7");
    // R5 deep power-down
    dpd_active = 1'b1;
    cmd(1, 0, 8, 0, "R5");
    cmd(9, 16'h0010, 40, 0, "R5");
    cmd(8, 0, 8, 0, "R5");
    dpd_active = 1'b0;
    cmd(9, 16'h0010, 40, 0, "R10");
    cmd(0, 0, 0, 0, "R10");
    // R6 one-time mode
    cmd(1, 0, 8, 0, "R3");
    cmd(3, 0, 16, 4'b0000, "R4");
    otp_mode = 1'b1;
    cmd(1, 0, 8, 0, "R3");
    cmd(4, 16'h0100, 40, 0, "R6");
    cmd(1, 0, 8, 0, "R3");
    cmd(3, 0, 16, 4'b0110, "R6");
    cmd(1, 0, 8, 0, "R3");
    cmd(4, 16'h0100, 40, 0, "R6");
    cmd(5, 16'h0100, 32, 0, "R6");
    otp_mode = 1'b0;
    cmd(3, 0, 16, 4'b0000, "R6");
    wp_n = 1'b0;
    cmd(1, 0, 8, 0, "R3");
    cmd(3, 0, 16, 4'b0000, "R4");
    wp_n = 1'b1;
    // R3 reset clears latch and lock
    do_reset("R3");
    power_up();
    // R8 erase with bp=000 executes
    cmd(1, 0, 8, 0, "R3");
    cmd(7, 0, 8, 0, "R8");
    cmd(1, 0, 8, 0, "R3");
    cmd(6, 0, 32, 0, "R8");
    tick();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule